// File: doc/BRIEF.md
# Inter-Port Mailbox with Maskable Interrupts

Two processors that share a dual-ported memory signal each other through this block. Each side has its own port with its own strobes, address and data. When a port's mailbox-select input is driven low, its six low address bits stop addressing the memory array and instead address a small register window. In that window each side finds four incoming mailboxes, four outgoing mailboxes, a mask register and a read-only view of its interrupt flags.

A write into one of a port's outgoing mailboxes stores the word and raises the matching interrupt flag at the opposite port. The receiving side reads its incoming mailbox to fetch the message, and that read clears the flag. Each port has an active-low interrupt output. It is driven low while any of that port's flags is set with its mask bit clear. Out of reset every mask bit is set, so software must unmask before it gets any interrupt.

All registers sit in one clock domain. Reads return data one cycle after the strobe, and flag, mask and interrupt changes show at the outputs one cycle after the access that causes them.

Top module: `dual_mailbox_irq`

## Requirements
- R1: After reset all eight mailbox words and all flags are zero, all four mask bits of each port are one, both interrupt outputs are high, and both read buses are zero.
- R2: While a port's mailbox select is high, its read and write strobes have no effect on any mailbox, flag or mask, and its read bus stays zero.
- R3: A write to offset 4+i (i = 0..3) of a port stores the word in that port's outgoing mailbox i. The opposite port reads it at its offset i and the writing port reads it back at offset 4+i.
- R4: A write to offset 4+i of a port sets bit i of the opposite port's flags. The flags read as bits [3:0] of offset 9, and the upper bits read zero.
- R5: A read of offset i (i = 0..3) of a port clears that port's flag bit i.
- R6: If the same flag bit is set by the opposite port's write and cleared by the own port's read in the same cycle, the flag ends up set.
- R7: Offset 8 holds the port's mask in bits [3:0]. A 1 masks the flag. A write stores only bits [3:0], and the upper bits read zero.
- R8: A port's interrupt output is low exactly when some flag bit is one and its mask bit is zero. It is updated in the cycle after the access that changes the flags or mask.
- R9: Reads of offsets 10..63 return zero. Writes to offsets 0..3, 9 and 10..63 change nothing.
- R10: The read bus carries the addressed word in the cycle after a read strobe with select low, and zero in every other cycle. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| a_mb_sel_n | input | 1 | Port A mailbox window select, active low |
| a_rd | input | 1 | Port A read strobe |
| a_wr | input | 1 | Port A write strobe |
| a_addr | input | 6 | Port A offset in the mailbox window |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one cycle after the strobe |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_mb_sel_n | input | 1 | Port B mailbox window select, active low |
| b_rd | input | 1 | Port B read strobe |
| b_wr | input | 1 | Port B write strobe |
| b_addr | input | 6 | Port B offset in the mailbox window |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one cycle after the strobe |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
Every result of this block is due exactly one clock after the strobe that causes it. That covers read data, flag sets and clears, mask updates and the interrupt level. The bench drives each access at a falling edge and advances its behavioural model at the next rising edge. It compares both read buses and both interrupt outputs at the following falling edge, so each comparison lands in the first cycle in which the new value is due. Read data from a read issued together with a write, and a flag hit by a set and a clear at once, are predicted from the state before that edge. This matches the one-cycle rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_IN   = 3'd1,
        ACC_OUT  = 3'd2,
        ACC_MASK = 3'd3,
        ACC_FLAG = 3'd4
    } acc_kind_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NUM_BOX = 4,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] OUT_BASE = ADDR_W'(NUM_BOX);
    localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(2 * NUM_BOX);
    localparam logic [ADDR_W-1:0] FLAG_OFF = ADDR_W'(2 * NUM_BOX + 1);

    always_comb begin
        kind = ACC_NONE;
        idx  = '0;
        if (!sel_n) begin
            if (addr < OUT_BASE) begin
                kind = ACC_IN;
                idx  = IDX_W'(addr);
            end else if (addr < MASK_OFF) begin
                kind = ACC_OUT;
                idx  = IDX_W'(addr - OUT_BASE);
            end else if (addr == MASK_OFF) begin
                kind = ACC_MASK;
            end else if (addr == FLAG_OFF) begin
                kind = ACC_FLAG;
            end
        end
    end

    // R2: a deselected port never decodes to a register
    always_comb begin
        if (sel_n) assert_deselect_none_R2: assert (kind == ACC_NONE);
    end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
    parameter int NUM_BOX = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BOX-1:0] set_vec,
    input  logic [NUM_BOX-1:0] clr_vec,
    input  logic               mask_we,
    input  logic [NUM_BOX-1:0] mask_wdata,
    output logic [NUM_BOX-1:0] flags_o,
    output logic [NUM_BOX-1:0] mask_o,
    output logic               irq_n_o
);

    typedef struct packed {
        logic [NUM_BOX-1:0] flags;
        logic [NUM_BOX-1:0] mask;
        logic               irq_n;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first, then sets: a coincident set survives
        st_d.flags = (st_q.flags & ~clr_vec) | set_vec;
        if (mask_we) st_d.mask = mask_wdata;
        st_d.irq_n = ~|(st_d.flags & ~st_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.mask  <= '1;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign mask_o  = st_q.mask;
    assign irq_n_o = st_q.irq_n;

    genvar gb;
    for (gb = 0; gb < NUM_BOX; gb++) begin : g_bit_chk
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[gb] |=> flags_o[gb]);
        assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[gb] && !set_vec[gb]) |=> !flags_o[gb]);
        assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[gb] && !set_vec[gb]) |=> $stable(flags_o[gb]));
    end

    assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_o));
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !(|(flags_o & ~mask_o)));

endmodule

// File: rtl/dual_mailbox_irq.sv
module dual_mailbox_irq
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    parameter int NUM_BOX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_mb_sel_n,
    input  logic              a_rd,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_mb_sel_n,
    input  logic              b_rd,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam int IDX_W = $clog2(NUM_BOX);
    localparam logic [ADDR_W-1:0] FIRST_UNUSED = ADDR_W'(2 * NUM_BOX + 2);

    // per-port views of the pins
    logic [NUM_PORTS-1:0]             sel_n_w, rd_w, wr_w, irq_n_w;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_w;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_w;
    logic [NUM_PORTS-1:0][IDX_W-1:0]  idx_w;
    acc_kind_e                        kind_w [NUM_PORTS];

    logic [NUM_PORTS-1:0][NUM_BOX-1:0] set_w, clr_w, flags_w, mask_w;
    logic [NUM_PORTS-1:0]              mask_we_w;

    assign sel_n_w = {b_mb_sel_n, a_mb_sel_n};
    assign rd_w    = {b_rd, a_rd};
    assign wr_w    = {b_wr, a_wr};
    assign addr_w  = {b_addr, a_addr};
    assign wdata_w = {b_wdata, a_wdata};

    typedef struct packed {
        logic [NUM_PORTS-1:0][NUM_BOX-1:0][DATA_W-1:0] box;   // box[p] is written by port p
        logic [NUM_PORTS-1:0][DATA_W-1:0]              rdata;
    } core_t;

    core_t core_d, core_q;

    genvar gp;
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        localparam int OP = NUM_PORTS - 1 - gp;

        mbx_decode #(
            .ADDR_W (ADDR_W),
            .NUM_BOX(NUM_BOX),
            .IDX_W  (IDX_W)
        ) u_dec (
            .sel_n(sel_n_w[gp]),
            .addr (addr_w[gp]),
            .kind (kind_w[gp]),
            .idx  (idx_w[gp])
        );

        mbx_irq_ctrl #(
            .NUM_BOX(NUM_BOX)
        ) u_irq (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_vec   (set_w[gp]),
            .clr_vec   (clr_w[gp]),
            .mask_we   (mask_we_w[gp]),
            .mask_wdata(wdata_w[gp][NUM_BOX-1:0]),
            .flags_o   (flags_w[gp]),
            .mask_o    (mask_w[gp]),
            .irq_n_o   (irq_n_w[gp])
        );

        // flag set at this port comes from the other port's outgoing write
        always_comb begin
            set_w[gp] = '0;
            clr_w[gp] = '0;
            if (wr_w[OP] && kind_w[OP] == ACC_OUT) set_w[gp][idx_w[OP]] = 1'b1;
            if (rd_w[gp] && kind_w[gp] == ACC_IN)  clr_w[gp][idx_w[gp]] = 1'b1;
        end

        assign mask_we_w[gp] = wr_w[gp] && (kind_w[gp] == ACC_MASK);

        assert_unused_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n_w[gp] && rd_w[gp] && addr_w[gp] >= FIRST_UNUSED) |=> core_q.rdata[gp] == '0);
        assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_w[gp] && !sel_n_w[gp]) |=> core_q.rdata[gp] == '0);
        assert_in_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_w[gp] && kind_w[gp] == ACC_IN && !(wr_w[OP] && kind_w[OP] == ACC_OUT))
            |=> $stable(core_q.box[OP]));
        assert_deselect_keeps_box_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_n_w[gp] && !(wr_w[OP] && !sel_n_w[OP])) |=> $stable(core_q.box));
    end

    always_comb begin
        logic pi;
        logic oi;
        core_d = core_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            pi = 1'(p);
            oi = ~pi;
            core_d.rdata[pi] = '0;
            if (rd_w[pi]) begin
                unique case (kind_w[pi])
                    ACC_IN:   core_d.rdata[pi] = core_q.box[oi][idx_w[pi]];
                    ACC_OUT:  core_d.rdata[pi] = core_q.box[pi][idx_w[pi]];
                    ACC_MASK: core_d.rdata[pi] = DATA_W'(mask_w[pi]);
                    ACC_FLAG: core_d.rdata[pi] = DATA_W'(flags_w[pi]);
                    default:  core_d.rdata[pi] = '0;
                endcase
            end
            if (wr_w[pi] && kind_w[pi] == ACC_OUT)
                core_d.box[pi][idx_w[pi]] = wdata_w[pi];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign a_rdata = core_q.rdata[0];
    assign b_rdata = core_q.rdata[1];
    assign a_irq_n = irq_n_w[0];
    assign b_irq_n = irq_n_w[1];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (a_irq_n && b_irq_n && a_rdata == '0 && b_rdata == '0));

endmodule

// File: tb/dual_mailbox_irq_test.sv
module dual_mailbox_irq_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [1:0]       sel_n, rd, wr;
    logic [1:0][5:0]  addr;
    logic [1:0][15:0] wdata;
    logic [15:0]      a_rdata, b_rdata;
    logic             a_irq_n, b_irq_n;

    int checks = 0;
    int errors = 0;

    // behavioural model
    logic [15:0] m_box [2][4];
    logic [3:0]  m_flag [2];
    logic [3:0]  m_mask [2];
    logic [15:0] m_rd [2];
    logic        m_irq_n [2];

    dual_mailbox_irq uut (
        .clk(clk), .rst_n(rst_n),
        .a_mb_sel_n(sel_n[0]), .a_rd(rd[0]), .a_wr(wr[0]), .a_addr(addr[0]),
        .a_wdata(wdata[0]), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_mb_sel_n(sel_n[1]), .b_rd(rd[1]), .b_wr(wr[1]), .b_addr(addr[1]),
        .b_wdata(wdata[1]), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sel_n = 2'b11; rd = '0; wr = '0; addr = '0; wdata = '0;
    endtask

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4; i++) m_box[p][i] = '0;
            m_flag[p] = '0; m_mask[p] = 4'hF; m_rd[p] = '0; m_irq_n[p] = 1'b1;
        end
    endtask

    task automatic model_step();
        logic [15:0] nbox [2][4];
        logic [3:0]  nflag [2];
        logic [3:0]  nmask [2];
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4; i++) nbox[p][i] = m_box[p][i];
            nflag[p] = m_flag[p]; nmask[p] = m_mask[p];
        end
        for (int p = 0; p < 2; p++) begin
            int o = 1 - p;
            int a = int'(addr[p]);
            m_rd[p] = '0;
            if (!sel_n[p] && rd[p]) begin
                if (a < 4) begin
                    m_rd[p] = m_box[o][a];
                    nflag[p][a] = 1'b0;
                end else if (a < 8) m_rd[p] = m_box[p][a - 4];
                else if (a == 8)    m_rd[p] = {12'h0, m_mask[p]};
                else if (a == 9)    m_rd[p] = {12'h0, m_flag[p]};
            end
        end
        for (int p = 0; p < 2; p++) begin
            int o = 1 - p;
            int a = int'(addr[p]);
            if (!sel_n[p] && wr[p]) begin
                if (a >= 4 && a < 8) begin
                    nbox[p][a - 4] = wdata[p];
                    nflag[o][a - 4] = 1'b1;
                end else if (a == 8) nmask[p] = wdata[p][3:0];
            end
        end
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4; i++) m_box[p][i] = nbox[p][i];
            m_flag[p] = nflag[p]; m_mask[p] = nmask[p];
            m_irq_n[p] = ~|(m_flag[p] & ~m_mask[p]);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "a_rdata", a_rdata, m_rd[0]);
        check(tag, "b_rdata", b_rdata, m_rd[1]);
        check(tag, "a_irq_n", {15'h0, a_irq_n}, {15'h0, m_irq_n[0]});
        check(tag, "b_irq_n", {15'h0, b_irq_n}, {15'h0, m_irq_n[1]});
    endtask

    // inputs set at a falling edge take effect at the next rising edge;
    // results are due one edge later and are compared at the falling edge
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic put(input int p, input logic s_n, input logic r, input logic w,
                       input int a, input logic [15:0] d);
        sel_n[p] = s_n; rd[p] = r; wr[p] = w; addr[p] = 6'(a); wdata[p] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        cycle("R1");
        // R1 / R7: reset mask reads all ones, flags zero
        put(0, 0, 1, 0, 8, 0); put(1, 0, 1, 0, 9, 0); cycle("R7");
        put(0, 0, 1, 0, 9, 0); put(1, 0, 1, 0, 8, 0); cycle("R1");
        // R3 / R4: A posts to outgoing box 0, flag rises at B but stays masked
        put(0, 0, 0, 1, 4, 16'h1234); cycle("R4");
        put(1, 0, 1, 0, 9, 0); cycle("R4");
        // R8: B unmasks everything, interrupt goes low
        put(1, 0, 0, 1, 8, 16'h0000); cycle("R8");
        // R5 / R3: B fetches message, flag clears, interrupt releases
        put(1, 0, 1, 0, 0, 0); cycle("R5");
        put(0, 0, 1, 0, 4, 0); put(1, 0, 1, 0, 9, 0); cycle("R3");
        // R2: deselected write and read do nothing
        put(0, 1, 1, 1, 5, 16'hBEEF); cycle("R2");
        put(1, 0, 1, 0, 1, 0); put(0, 1, 1, 0, 8, 0); cycle("R2");
        put(1, 0, 1, 0, 9, 0); cycle("R2");
        // R9: writes to incoming, flag view and unused offsets ignored
        put(1, 0, 0, 1, 0, 16'hAAAA); put(0, 0, 0, 1, 9, 16'h000F); cycle("R9");
        put(1, 0, 0, 1, 20, 16'h5555); put(0, 0, 0, 1, 63, 16'hFFFF); cycle("R9");
        put(1, 0, 1, 0, 0, 0); put(0, 0, 1, 0, 9, 0); cycle("R9");
        put(1, 0, 1, 0, 20, 0); put(0, 0, 1, 0, 63, 0); cycle("R9");
        put(0, 0, 1, 0, 10, 0); put(1, 0, 1, 0, 4, 0); cycle("R9");
        // R6: set and clear of B flag 2 in one cycle, set wins
        put(0, 0, 0, 1, 6, 16'h0BAD); cycle("R6");
        put(0, 0, 0, 1, 6, 16'h0C0D); put(1, 0, 1, 0, 2, 0); cycle("R6");
        put(1, 0, 1, 0, 9, 0); cycle("R6");
        put(1, 0, 1, 0, 2, 0); cycle("R5");
        // R10: read with write in same cycle returns old value
        put(0, 0, 1, 1, 7, 16'h7777); cycle("R10");
        put(0, 0, 1, 0, 7, 0); cycle("R10");
        put(1, 0, 1, 0, 3, 0); cycle("R5");
        // R7: partial mask and upper bits dropped
        put(1, 0, 0, 1, 8, 16'hFFFE); cycle("R7");
        put(1, 0, 1, 0, 8, 0); put(0, 0, 0, 1, 5, 16'h1111); cycle("R8");
        put(0, 0, 0, 1, 4, 16'h2222); cycle("R8");
        put(1, 0, 1, 0, 0, 0); cycle("R8");
        put(1, 0, 1, 0, 1, 0); cycle("R5");
        // R4 reverse direction: B posts to A, A unmasks in same cycle
        put(1, 0, 0, 1, 7, 16'h3C3C); put(0, 0, 0, 1, 8, 16'h0000); cycle("R4");
        put(0, 0, 1, 0, 9, 0); cycle("R4");
        put(0, 0, 1, 0, 3, 0); cycle("R5");
        // R3: mixed traffic, compared every cycle against the model
        for (int n = 0; n < 400; n++) begin
            for (int p = 0; p < 2; p++) begin
                int pick = int'($urandom_range(0, 11));
                int a = (pick < 10) ? pick : ((pick == 10) ? 13 : 40);
                put(p, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), a, 16'($urandom));
            end
            cycle("R3");
        end
        // R1: reset mid-run brings everything back
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare("R1");
        put(0, 0, 1, 0, 8, 0); put(1, 0, 1, 0, 0, 0); cycle("R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule